// File: doc/BRIEF.md
# Chip-Select Segment Decoder

This block keeps one segment register for each chip select of a serial flash controller and uses them to map a bus address inside a shared flash window onto a chip-select index and a byte offset inside that device. A segment register gives the first and the one-past-last address of its range in 8 MB units. An address belongs to a segment when it lies at or above the start and below the end.

Each write to a segment register is validated before it takes effect. Chip select 0 always begins at the window base, whatever value is written. A range that lies wholly outside the flash window is refused and the old value is kept. A range whose start is not a multiple of its size is flagged, and so is a range that overlaps another chip select's range. Both of those are still applied. A write that carries exactly the current value is dropped. Errors collect in sticky flags that only reset clears. Reset loads a default layout: one larger first segment at the window base, followed by smaller segments packed end to end.

Top module: `cs_segment_decoder`

## Requirements
- R1: A segment word keeps the end in bits [31:24] and the start in bits [23:16], each in 8 MB units. Bits [15:0] always read as zero, and any written low bits are discarded.
- R2: After reset, chip select 0 spans FIRST_UNITS units from the window base. Each further chip select spans REST_UNITS units and begins where the previous one ends. With the defaults the words are 0x48400000, 0x4C480000, 0x504C0000, 0x54500000 and 0x58540000.
- R3: Any write to chip select 0 stores the window base as the start field and keeps the written end field.
- R4: A write whose end address is at or below the window base, or whose start address is at or above the window top, is refused. The register keeps its value and the flag err_window is set until the next reset.
- R5: A write with a non-zero size whose start is not a multiple of its size is stored and sets the sticky flag err_align.
- R6: A write with a non-zero size whose range shares any address with another chip select's non-empty range is stored and sets the sticky flag err_overlap.
- R7: A write whose full 32-bit value equals the current register word changes nothing and sets no flag.
- R8: An address that lies inside one segment drives dec_hit=1, the index of that chip select on dec_cs, and address minus segment start on dec_offset, in the same cycle.
- R9: When several segments contain the address, the lowest-numbered chip select is reported.
- R10: An address that lies in no segment gives dec_hit=0, dec_cs=0 and dec_offset=0. If acc_valid is high, the sticky flag err_miss is set from the next cycle on.
- R11: A write to a register index at or above NUM_CS has no effect, and reading such an index returns zero.
- R12: A segment whose end is not above its start has size zero. It never matches an address and is never flagged as misaligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Segment register write strobe |
| reg_idx | input | IDX_W | Register index for both write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current word of the indexed register (combinational) |
| acc_valid | input | 1 | Address on acc_addr is a real access (enables miss flag) |
| acc_addr | input | ADDR_W | Bus address to decode |
| dec_hit | output | 1 | Address lies in some segment |
| dec_cs | output | IDX_W | Selected chip select |
| dec_offset | output | ADDR_W | Byte offset inside the selected segment |
| err_window | output | 1 | Sticky: a write was refused as outside the window |
| err_align | output | 1 | Sticky: a stored segment was misaligned |
| err_overlap | output | 1 | Sticky: a stored segment overlapped another |
| err_miss | output | 1 | Sticky: a valid access hit no segment |

## Verification
The decode outputs and reg_rdata are combinational. They are due in the same cycle as the address or index that produces them. A register write and every error flag take effect at the rising edge that samples the strobe, so they show up one cycle later. The bench drives inputs just after the falling edge and then compares all outputs against a behavioural model whose state has not yet advanced. It moves the model state forward only across the following rising edge, so each result is checked exactly in the cycle it is due.

// File: rtl/segdec_pkg.sv
package segdec_pkg;

   // Register layout: upper byte is the end unit, next byte the start unit.
   localparam int FIELD_W = 8;
   localparam int WORD_W  = 32;
   localparam int HALF_W  = 16;

   typedef struct packed {
      logic [FIELD_W-1:0] hi_u;   // one past last unit
      logic [FIELD_W-1:0] lo_u;   // first unit
   } seg_fld_t;

   function automatic logic [FIELD_W-1:0] span_units(input seg_fld_t f);
      return (f.hi_u > f.lo_u) ? (f.hi_u - f.lo_u) : '0;
   endfunction

endpackage

// File: rtl/segdec_check.sv
module segdec_check
   import segdec_pkg::*;
#(
   parameter int NUM_CS  = 5,
   parameter int IDX_W   = 3,
   parameter int BASE_U  = 64,
   parameter int LIMIT_U = 96
) (
   input  logic [IDX_W-1:0] idx,
   input  seg_fld_t         wr_fld,
   input  seg_fld_t         cur_fld [NUM_CS],
   output seg_fld_t         new_fld,
   output logic             bad_window,
   output logic             bad_align,
   output logic             overlaps
);

   logic [FIELD_W-1:0] n_sz;

   // chip select 0 keeps its start pinned to the window base (R3)
   always_comb begin
      new_fld.hi_u = wr_fld.hi_u;
      new_fld.lo_u = (idx == '0) ? FIELD_W'(BASE_U) : wr_fld.lo_u;
   end

   always_comb begin
      n_sz       = span_units(new_fld);
      bad_window = ({1'b0, new_fld.hi_u} <= 9'(BASE_U)) ||
                   ({1'b0, new_fld.lo_u} >= 9'(LIMIT_U));
      bad_align  = (n_sz != '0) && ((new_fld.lo_u % n_sz) != '0);
   end

   always_comb begin
      overlaps = 1'b0;
      for (int i = 0; i < NUM_CS; i++) begin
         if (i != int'(idx) && n_sz != '0 && span_units(cur_fld[i]) != '0 &&
             new_fld.lo_u < cur_fld[i].hi_u && cur_fld[i].lo_u < new_fld.hi_u)
            overlaps = 1'b1;
      end
   end

endmodule

// File: rtl/segdec_match.sv
module segdec_match
   import segdec_pkg::*;
#(
   parameter int NUM_CS = 5,
   parameter int IDX_W  = 3,
   parameter int ADDR_W = 32,
   parameter int SHIFT  = 23
) (
   input  logic [ADDR_W-1:0] addr,
   input  seg_fld_t          fld [NUM_CS],
   output logic              hit,
   output logic [IDX_W-1:0]  cs,
   output logic [ADDR_W-1:0] offset
);

   localparam int UW = ADDR_W - SHIFT;

   logic [UW-1:0]     unit;
   logic [NUM_CS-1:0] in_seg;
   logic [ADDR_W-1:0] seg_base [NUM_CS];

   assign unit = addr[ADDR_W-1:SHIFT];

   for (genvar g = 0; g < NUM_CS; g++) begin : g_cmp
      assign seg_base[g] = ADDR_W'(fld[g].lo_u) << SHIFT;
      assign in_seg[g]   = (unit >= UW'(fld[g].lo_u)) && (unit < UW'(fld[g].hi_u));
   end

   // scan from the top so the lowest index is the last to claim (R9)
   always_comb begin
      hit    = 1'b0;
      cs     = '0;
      offset = '0;
      for (int i = NUM_CS - 1; i >= 0; i--) begin
         if (in_seg[i]) begin
            hit    = 1'b1;
            cs     = IDX_W'(i);
            offset = addr - seg_base[i];
         end
      end
   end

endmodule

// File: rtl/cs_segment_decoder.sv
module cs_segment_decoder
   import segdec_pkg::*;
#(
   parameter int          NUM_CS      = 5,
   parameter int          IDX_W       = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
   parameter int          ADDR_W      = 32,
   parameter int          UNIT_SHIFT  = 23,
   parameter logic [31:0] WIN_BASE    = 32'h2000_0000,
   parameter logic [31:0] WIN_SIZE    = 32'h1000_0000,
   parameter int          FIRST_UNITS = 8,
   parameter int          REST_UNITS  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [IDX_W-1:0]  reg_idx,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   output logic              dec_hit,
   output logic [IDX_W-1:0]  dec_cs,
   output logic [ADDR_W-1:0] dec_offset,
   output logic              err_window,
   output logic              err_align,
   output logic              err_overlap,
   output logic              err_miss
);

   localparam int BASE_U  = int'(WIN_BASE >> UNIT_SHIFT);
   localparam int LIMIT_U = int'((WIN_BASE + WIN_SIZE) >> UNIT_SHIFT);
   localparam int LAST_U  = BASE_U + FIRST_UNITS + (NUM_CS - 1) * REST_UNITS;

   // elaboration-time parameter checks
   if (ADDR_W - UNIT_SHIFT < FIELD_W) begin : g_bad_shift
      $error("address above the unit shift must cover the 8-bit fields");
   end
   if ((WIN_BASE & ((32'd1 << UNIT_SHIFT) - 32'd1)) != 32'd0) begin : g_bad_base
      $error("window base must sit on a unit boundary");
   end
   if (LIMIT_U > 256) begin : g_bad_limit
      $error("window top exceeds the 8-bit unit fields");
   end
   if (LAST_U > LIMIT_U) begin : g_bad_defaults
      $error("default layout does not fit the window");
   end
   if (IDX_W < 1 || (1 << IDX_W) < NUM_CS) begin : g_bad_idx
      $error("IDX_W too narrow for NUM_CS");
   end

   seg_fld_t seg_q [NUM_CS];
   seg_fld_t cur_fld;
   seg_fld_t new_fld;
   logic     idx_ok, upd, chk_window, chk_align, chk_ovl;

   assign idx_ok = int'(reg_idx) < NUM_CS;

   always_comb begin
      cur_fld = '0;
      for (int i = 0; i < NUM_CS; i++)
         if (int'(reg_idx) == i) cur_fld = seg_q[i];
   end

   assign reg_rdata = idx_ok ? {cur_fld, 16'h0000} : 32'h0;
   assign upd       = reg_wr && idx_ok && (reg_wdata != {cur_fld, 16'h0000});

   segdec_check #(
      .NUM_CS (NUM_CS),
      .IDX_W  (IDX_W),
      .BASE_U (BASE_U),
      .LIMIT_U(LIMIT_U)
   ) u_check (
      .idx       (reg_idx),
      .wr_fld    (reg_wdata[31:16]),
      .cur_fld   (seg_q),
      .new_fld   (new_fld),
      .bad_window(chk_window),
      .bad_align (chk_align),
      .overlaps  (chk_ovl)
   );

   for (genvar g = 0; g < NUM_CS; g++) begin : g_seg
      localparam int D_LO = BASE_U + ((g == 0) ? 0 : FIRST_UNITS + (g - 1) * REST_UNITS);
      localparam int D_HI = D_LO + ((g == 0) ? FIRST_UNITS : REST_UNITS);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            seg_q[g] <= '{hi_u: FIELD_W'(D_HI), lo_u: FIELD_W'(D_LO)};
         else if (upd && reg_idx == IDX_W'(g) && !chk_window)
            seg_q[g] <= new_fld;
      end

      p_reject_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_wr && reg_idx == IDX_W'(g) && chk_window) |=> $stable(seg_q[g]))
         else $error("refused write changed segment %0d", g);

      p_same_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_wr && reg_idx == IDX_W'(g) && reg_wdata == {seg_q[g], 16'h0000})
         |=> $stable(seg_q[g]))
         else $error("identical write changed segment %0d", g);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_window  <= 1'b0;
         err_align   <= 1'b0;
         err_overlap <= 1'b0;
         err_miss    <= 1'b0;
      end else begin
         if (upd && chk_window)              err_window  <= 1'b1;
         if (upd && !chk_window && chk_align) err_align   <= 1'b1;
         if (upd && !chk_window && chk_ovl)   err_overlap <= 1'b1;
         if (acc_valid && !dec_hit)          err_miss    <= 1'b1;
      end
   end

   segdec_match #(
      .NUM_CS(NUM_CS),
      .IDX_W (IDX_W),
      .ADDR_W(ADDR_W),
      .SHIFT (UNIT_SHIFT)
   ) u_match (
      .addr  (acc_addr),
      .fld   (seg_q),
      .hit   (dec_hit),
      .cs    (dec_cs),
      .offset(dec_offset)
   );

   p_cs0_base_r3: assert property (@(posedge clk) disable iff (!rst_n)
      seg_q[0].lo_u == FIELD_W'(BASE_U))
      else $error("chip select 0 start left the window base");

   p_miss_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !dec_hit) |=> err_miss)
      else $error("missed access did not raise err_miss");

   p_window_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      err_window |=> err_window)
      else $error("err_window dropped without reset");

   p_miss_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_hit |-> (dec_cs == '0 && dec_offset == '0))
      else $error("decode outputs not cleared on a miss");

endmodule

// File: tb/cs_segment_decoder_tb.sv
`timescale 1ns/100ps
module cs_segment_decoder_tb;

   localparam int      N     = 5;
   localparam int      IW    = 3;
   localparam longint  BASE  = 64'h2000_0000;
   localparam longint  TOP   = 64'h3000_0000;
   localparam longint  UNIT  = 64'h0080_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [IW-1:0] reg_idx = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        acc_valid = 1'b0;
   logic [31:0] acc_addr = '0;
   logic        dec_hit;
   logic [IW-1:0] dec_cs;
   logic [31:0] dec_offset;
   logic        err_window, err_align, err_overlap, err_miss;

   int total = 0;
   int fails = 0;

   always #2.5 clk = ~clk;

   cs_segment_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
      .acc_addr(acc_addr), .dec_hit(dec_hit), .dec_cs(dec_cs),
      .dec_offset(dec_offset), .err_window(err_window), .err_align(err_align),
      .err_overlap(err_overlap), .err_miss(err_miss)
   );

   // ---------------- behavioural reference model ----------------
   longint mlo[N];
   longint mhi[N];
   bit m_win, m_align, m_ovl, m_miss;

   task automatic m_reset();
      for (int i = 0; i < N; i++) begin
         mlo[i] = BASE + ((i == 0) ? 0 : (8 + (i - 1) * 4)) * UNIT;
         mhi[i] = mlo[i] + ((i == 0) ? 8 : 4) * UNIT;
      end
      m_win = 0; m_align = 0; m_ovl = 0; m_miss = 0;
   endtask

   function automatic longint m_word(int i);
      return ((mhi[i] / UNIT) << 24) | ((mlo[i] / UNIT) << 16);
   endfunction

   function automatic longint m_size(longint lo, longint hi);
      return (hi > lo) ? hi - lo : 0;
   endfunction

   task automatic m_write(int i, longint w);
      longint lo, hi, sz;
      if (i >= N) return;
      if (w == m_word(i)) return;
      hi = ((w >> 24) & 'hff) * UNIT;
      lo = (i == 0) ? BASE : ((w >> 16) & 'hff) * UNIT;
      if (hi <= BASE || lo >= TOP) begin
         m_win = 1;
         return;
      end
      sz = m_size(lo, hi);
      if (sz != 0 && (lo % sz) != 0) m_align = 1;
      for (int k = 0; k < N; k++)
         if (k != i && sz != 0 && m_size(mlo[k], mhi[k]) != 0 &&
             lo < mhi[k] && mlo[k] < hi) m_ovl = 1;
      mlo[i] = lo;
      mhi[i] = hi;
   endtask

   task automatic m_decode(longint a, output bit h, output int c, output longint off);
      h = 0; c = 0; off = 0;
      for (int i = 0; i < N; i++)
         if (!h && a >= mlo[i] && a < mhi[i]) begin
            h = 1; c = i; off = a - mlo[i];
         end
   endtask

   task automatic check(string tag, string what, longint act, longint exp);
      total++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
      end
   endtask

   // one cycle: drive, compare against unadvanced model, advance at the edge
   task automatic cyc(string tag, bit wr, int idx, longint wd, bit av, longint a);
      bit h; int c; longint off;
      @(negedge clk);
      reg_wr = wr; reg_idx = IW'(idx); reg_wdata = wd[31:0];
      acc_valid = av; acc_addr = a[31:0];
      #1;
      check(tag, "rdata", longint'(reg_rdata), (idx < N) ? m_word(idx) : 0);
      m_decode(a, h, c, off);
      check(tag, "decode", {dec_hit, 8'(dec_cs), dec_offset}, {h, 8'(c), off[31:0]});
      check(tag, "flags", {err_window, err_align, err_overlap, err_miss},
            {m_win, m_align, m_ovl, m_miss});
      if (wr) m_write(idx, wd);
      if (av && !h) m_miss = 1;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0; reg_wr = 0; acc_valid = 0;
      repeat (2) @(negedge clk);
      m_reset();
      rst_n = 1;
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", total - fails, total);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++; fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      do_reset();
      // R2: reset layout read back, plus explicit word values
      for (int i = 0; i < N; i++) cyc("R2", 0, i, 0, 0, 0);
      cyc("R2", 0, 0, 0, 0, 0);
      check("R2", "cs0 word", longint'(reg_rdata), 64'h4840_0000);
      cyc("R2", 0, 4, 0, 0, 0);
      check("R2", "cs4 word", longint'(reg_rdata), 64'h5854_0000);

      // R11: out-of-range index
      cyc("R11", 1, 6, 64'hFFFF_0000, 0, 0);
      cyc("R11", 0, 6, 0, 0, 0);
      check("R11", "idx6 read", longint'(reg_rdata), 0);
      cyc("R11", 0, 5, 0, 0, 0);

      // R8: decoding inside segments
      cyc("R8", 0, 0, 0, 1, 64'h2000_0000);
      cyc("R8", 0, 0, 0, 1, 64'h23FF_FFFF);
      cyc("R8", 0, 1, 0, 1, 64'h2400_0004);
      check("R8", "cs1 index", longint'(dec_cs), 1);
      cyc("R8", 0, 4, 0, 1, 64'h2B00_0100);
      check("R8", "cs4 offset", longint'(dec_offset), 64'h0100_0100);

      // R10: misses
      cyc("R10", 0, 0, 0, 1, 64'h2C00_0000);
      check("R10", "miss hit", longint'(dec_hit), 0);
      cyc("R10", 0, 0, 0, 0, 64'h1000_0000);
      check("R10", "miss flag", longint'(err_miss), 1);

      // R1: low bits dropped
      do_reset();
      cyc("R1", 1, 1, 64'h4C48_ABCD, 0, 0);
      cyc("R1", 0, 1, 0, 0, 0);
      check("R1", "low bits", longint'(reg_rdata), 64'h4C48_0000);

      // R3: cs0 start pinned
      cyc("R3", 1, 0, 64'h4410_0000, 0, 0);
      cyc("R3", 0, 0, 0, 1, 64'h2300_0000);
      check("R3", "cs0 word", longint'(reg_rdata), 64'h4440_0000);
      cyc("R3", 0, 0, 0, 0, 64'h2200_0000);

      // R4: outside window refused
      cyc("R4", 1, 2, 64'h2010_0000, 0, 0);
      cyc("R4", 0, 2, 0, 0, 0);
      check("R4", "kept", longint'(reg_rdata), 64'h504C_0000);
      check("R4", "flag", longint'(err_window), 1);
      cyc("R4", 1, 3, 64'h7060_0000, 0, 0);
      cyc("R4", 0, 3, 0, 0, 0);

      // R5: misaligned applied and flagged
      do_reset();
      cyc("R5", 1, 3, 64'h5650_0000, 0, 0);
      cyc("R5", 0, 3, 0, 1, 64'h2A80_0000);
      check("R5", "align flag", longint'(err_align), 1);

      // R6 / R9: overlap applied, lowest index wins
      do_reset();
      cyc("R6", 1, 1, 64'h4E48_0000, 0, 0);
      cyc("R6", 0, 1, 0, 0, 0);
      check("R6", "overlap flag", longint'(err_overlap), 1);
      cyc("R9", 0, 2, 0, 1, 64'h2600_0000);
      check("R9", "lowest cs", longint'(dec_cs), 1);
      cyc("R9", 0, 2, 0, 1, 64'h2700_0000);

      // R7: identical write
      do_reset();
      cyc("R7", 1, 1, 64'h4C48_0000, 0, 0);
      cyc("R7", 1, 0, 64'h4840_0000, 0, 0);
      cyc("R7", 0, 1, 0, 0, 0);
      check("R7", "no flags", {err_window, err_align, err_overlap}, 0);

      // R12: zero-size segment
      do_reset();
      cyc("R12", 1, 4, 64'h5458_0000, 0, 0);
      cyc("R12", 0, 4, 0, 1, 64'h2A00_0000);
      check("R12", "no hit", longint'(dec_hit), 0);
      cyc("R12", 0, 4, 0, 1, 64'h2B00_0000);
      check("R12", "no align", longint'(err_align), 0);

      summary();
      $finish;
   end

endmodule